// File: doc/BRIEF.md
# Four-Bit Multi-Mode Ripple Arithmetic Slice

This block is a four-bit arithmetic slice. One ripple carry chain is shared by four behaviours, picked by a two-bit mode input. The counter mode steps a value up or down by the carry-in. The multiply-step mode adds the multiplicand to a partial product only when the multiplier bit is set. The equality mode raises an inequality flag that can be cascaded. The subtract mode gives a difference and a no-borrow flag, which together serve as a magnitude compare. The combinational result `f` and the carry output `cout` are always visible. Four flip-flops, with a clock enable and a synchronous reset, capture `f` on `q`.

Wider operands are built by wiring `cout` of one slice to `cin` of the next, more significant slice. To form a counter, `q` is routed back to `a`, and the least significant slice gets `cin` = 1. There are no internal states beyond the four result flip-flops. The mode decode behaves as a four-way selector with the named choices MODE_COUNT, MODE_MULSTEP, MODE_EQ and MODE_SUB. The register has two transitions on a clock edge, LOAD (`en` = 1) and HOLD (`en` = 0), and reset takes priority over both.

Top module: `ras_slice`

## Requirements
- R1: With mode 2'b00 (count) and `a4` = 1 (up), `f` = (`a` + `cin`) mod 16 and `cout` = 1 exactly when `a` = 4'hF and `cin` = 1; `b` has no effect.
- R2: With mode 2'b00 and `a4` = 0 (down), `f` = (`a` − `cin`) mod 16 and `cout` = 1 exactly when `a` = 4'h0 and `cin` = 1.
- R3: With mode 2'b01 (multiply step), {`cout`,`f`} = `a` + (`a4` ? `b` : 0) + `cin` as a five-bit sum.
- R4: With mode 2'b10 (equality), `cout` = 1 when `cin` = 1 or `a` ≠ `b`, otherwise 0; `f` = `a` XOR `b`.
- R5: With mode 2'b11 (subtract), `f` = (`a` − `b` − (1 − `cin`)) mod 16 and `cout` = 1 exactly when `a` ≥ `b` + (1 − `cin`); `cin` = 1 means no borrow in.
- R6: On a rising clock edge with `rst` = 0 and `en` = 1, `q` takes the value `f` had before the edge.
- R7: On a rising clock edge with `rst` = 0 and `en` = 0, `q` keeps its value.
- R8: On a rising clock edge with `rst` = 1, `q` becomes 4'h0 whatever `en` is.
- R9: With `q` fed back to `a`, mode count, `a4` = 1 and `cin` = 1, `q` steps 0,1,…,F,0 on successive enabled edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the result register |
| rst | input | 1 | Synchronous active-high reset of `q` |
| en | input | 1 | Clock enable of the result register |
| mode | input | 2 | 00 count, 01 multiply step, 10 equality, 11 subtract |
| a | input | 4 | Count value, partial product, or first operand |
| a4 | input | 1 | Count direction (1 up) or multiplier bit |
| b | input | 4 | Multiplicand or second operand |
| cin | input | 1 | Carry, borrow-free flag, or cascaded inequality in |
| f | output | 4 | Combinational result |
| cout | output | 1 | Carry, wrap, no-borrow, or inequality out |
| q | output | 4 | Registered result |

## Verification
Each mode has only a few gates between the inputs and `f`/`cout`. A wrong operand select or a wrong carry sense therefore shows up on the outputs in the same cycle, and the table of vectors catches it within one step for each mode. A fault in the register shows at `q` one edge later: a missed load, a lost hold, or reset losing its priority. In the feedback counting run, any faulty step is repeated on every later value of the sequence.

// File: rtl/ras_pkg.sv
package ras_pkg;
    localparam int SLICE_W = 4;

    typedef enum logic [1:0] {
        MODE_COUNT   = 2'b00,
        MODE_MULSTEP = 2'b01,
        MODE_EQ      = 2'b10,
        MODE_SUB     = 2'b11
    } ras_mode_e;
endpackage

// File: rtl/ras_operand_mux.sv
module ras_operand_mux
    import ras_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  ras_mode_e      mode,
    input  logic [W-1:0]   a,
    input  logic           a4,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   opx,
    output logic [W-1:0]   opy,
    output logic           c0
);
    always_comb begin
        opx = a;
        opy = '0;
        c0  = 1'b0;
        unique case (mode)
            MODE_COUNT: begin
                if (a4) begin
                    opy = '0;
                    c0  = cin;
                end else begin
                    opy = {W{cin}};
                    c0  = 1'b0;
                end
            end
            MODE_MULSTEP: begin
                opy = a4 ? b : '0;
                c0  = cin;
            end
            MODE_EQ: begin
                opy = '0;
                c0  = 1'b0;
            end
            MODE_SUB: begin
                opy = ~b;
                c0  = cin;
            end
        endcase
    end
endmodule

// File: rtl/ras_carry_chain.sv
module ras_carry_chain #(
    parameter int W = 4
) (
    input  logic [W-1:0] opx,
    input  logic [W-1:0] opy,
    input  logic         c0,
    output logic [W-1:0] sum,
    output logic         carry
);
    logic [W:0] cy;

    assign cy[0] = c0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = opx[i] ^ opy[i] ^ cy[i];
        assign cy[i+1] = (opx[i] & opy[i]) | (cy[i] & (opx[i] ^ opy[i]));
    end

    assign carry = cy[W];
endmodule

// File: rtl/ras_result_sel.sv
module ras_result_sel
    import ras_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  ras_mode_e      mode,
    input  logic [W-1:0]   a,
    input  logic           a4,
    input  logic [W-1:0]   b,
    input  logic           cin,
    input  logic [W-1:0]   sum,
    input  logic           carry,
    output logic [W-1:0]   f,
    output logic           cout
);
    logic [W-1:0] diff_bits;

    assign diff_bits = a ^ b;

    always_comb begin
        f    = sum;
        cout = carry;
        unique case (mode)
            MODE_COUNT: begin
                f    = sum;
                cout = a4 ? carry : (cin & ~carry);
            end
            MODE_MULSTEP: begin
                f    = sum;
                cout = carry;
            end
            MODE_EQ: begin
                f    = diff_bits;
                cout = cin | (|diff_bits);
            end
            MODE_SUB: begin
                f    = sum;
                cout = carry;
            end
        endcase
    end
endmodule

// File: rtl/ras_qbank.sv
module ras_qbank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= d;
    end

    AST_LOAD_ON_EN: assert property (@(posedge clk) disable iff (rst)
        en |=> (q == $past(d))); // R6
    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q)); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (q == '0)); // R8
endmodule

// File: rtl/ras_slice.sv
module ras_slice
    import ras_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [1:0]   mode,
    input  logic [W-1:0] a,
    input  logic         a4,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] f,
    output logic         cout,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    ras_mode_e    mode_e;
    logic [W-1:0] opx, opy, sum;
    logic         c0, carry;

    assign mode_e = ras_mode_e'(mode);

    ras_operand_mux #(.W(W)) u_opmux (
        .mode (mode_e), .a (a), .a4 (a4), .b (b), .cin (cin),
        .opx (opx), .opy (opy), .c0 (c0)
    );

    ras_carry_chain #(.W(W)) u_chain (
        .opx (opx), .opy (opy), .c0 (c0), .sum (sum), .carry (carry)
    );

    ras_result_sel #(.W(W)) u_rsel (
        .mode (mode_e), .a (a), .a4 (a4), .b (b), .cin (cin),
        .sum (sum), .carry (carry), .f (f), .cout (cout)
    );

    ras_qbank #(.W(W)) u_qbank (
        .clk (clk), .rst (rst), .en (en), .d (f), .q (q)
    );

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && a4 && cin) |-> (cout == (a == ALL_ONES))); // R1
    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && !a4 && cin) |-> (cout == (a == '0))); // R2
    AST_MUL_PASS: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && !a4 && !cin) |-> (f == a && !cout)); // R3
    AST_EQ_FLAG: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && !cin) |-> (cout == (a != b))); // R4
    AST_SUB_NOBORROW: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && cin) |-> (cout == (a >= b))); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && a4 && cin && en && a == q) |=> (q == $past(q) + 1'b1)); // R9
endmodule

// File: tb/sim_ras_slice.sv
module sim_ras_slice;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    // fields: req, mode, a4, a, b, cin, expected f, expected cout
    localparam logic [20:0] VEC [0:NVEC-1] = '{
        {4'd1, 2'b00, 1'b1, 4'h5, 4'h9, 1'b1, 4'h6, 1'b0},
        {4'd1, 2'b00, 1'b1, 4'hF, 4'h0, 1'b1, 4'h0, 1'b1},
        {4'd1, 2'b00, 1'b1, 4'h7, 4'h3, 1'b0, 4'h7, 1'b0},
        {4'd2, 2'b00, 1'b0, 4'h5, 4'hA, 1'b1, 4'h4, 1'b0},
        {4'd2, 2'b00, 1'b0, 4'h0, 4'h0, 1'b1, 4'hF, 1'b1},
        {4'd2, 2'b00, 1'b0, 4'h0, 4'h6, 1'b0, 4'h0, 1'b0},
        {4'd3, 2'b01, 1'b1, 4'h3, 4'h5, 1'b0, 4'h8, 1'b0},
        {4'd3, 2'b01, 1'b1, 4'hC, 4'h7, 1'b1, 4'h4, 1'b1},
        {4'd3, 2'b01, 1'b0, 4'h9, 4'hF, 1'b0, 4'h9, 1'b0},
        {4'd3, 2'b01, 1'b0, 4'hF, 4'h3, 1'b1, 4'h0, 1'b1},
        {4'd4, 2'b10, 1'b0, 4'h6, 4'h6, 1'b0, 4'h0, 1'b0},
        {4'd4, 2'b10, 1'b0, 4'h6, 4'h7, 1'b0, 4'h1, 1'b1},
        {4'd4, 2'b10, 1'b1, 4'hA, 4'hA, 1'b1, 4'h0, 1'b1},
        {4'd5, 2'b11, 1'b0, 4'h9, 4'h4, 1'b1, 4'h5, 1'b1},
        {4'd5, 2'b11, 1'b0, 4'h4, 4'h9, 1'b1, 4'hB, 1'b0},
        {4'd5, 2'b11, 1'b0, 4'h7, 4'h7, 1'b1, 4'h0, 1'b1},
        {4'd5, 2'b11, 1'b0, 4'h7, 4'h7, 1'b0, 4'hF, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst, en, a4, cin, fb;
    logic [1:0] mode;
    logic [3:0] a_vec, a, b, f, q;
    logic       cout;
    int         checks = 0;
    int         errors = 0;
    logic       done = 1'b0;

    assign a = fb ? q : a_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    ras_slice u0 (
        .clk (clk), .rst (rst), .en (en), .mode (mode), .a (a), .a4 (a4),
        .b (b), .cin (cin), .f (f), .cout (cout), .q (q)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 1'b0; fb = 1'b0; mode = 2'b00; a4 = 1'b0;
        a_vec = 4'h0; b = 4'h0; cin = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R8 reset", {1'b0, q}, 5'h00);
        rst = 1'b0;

        // combinational table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {mode, a4, a_vec, b, cin} = VEC[i][16:5];
            #1;
            check($sformatf("R%0d vec%0d", VEC[i][20:17], i), {cout, f},
                  {VEC[i][0], VEC[i][4:1]});
        end

        // R6 load: subtract 9-4 -> 5
        @(negedge clk);
        mode = 2'b11; a_vec = 4'h9; b = 4'h4; cin = 1'b1; en = 1'b1;
        @(negedge clk);
        check("R6 load", {1'b0, q}, 5'h05);

        // R7 hold: inputs change, enable off
        en = 1'b0; a_vec = 4'hE; b = 4'h1;
        @(negedge clk); @(negedge clk);
        check("R7 hold", {1'b0, q}, 5'h05);

        // R9 counting with feedback from q
        rst = 1'b1; en = 1'b1;
        @(negedge clk);
        rst = 1'b0; fb = 1'b1; mode = 2'b00; a4 = 1'b1; cin = 1'b1;
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk);
            check("R9 count", {1'b0, q}, {1'b0, 4'(k)});
        end

        // R2 down counting with feedback
        a4 = 1'b0;
        @(negedge clk);
        check("R2 down step", {1'b0, q}, 5'h01);
        @(negedge clk);
        check("R2 down step", {1'b0, q}, 5'h00);
        #1;
        check("R2 down wrap flag", {cout, f}, 5'h1F);

        // R8 reset wins over enable
        rst = 1'b1; en = 1'b1; fb = 1'b0; a_vec = 4'h7; a4 = 1'b1;
        @(negedge clk);
        check("R8 reset priority", {1'b0, q}, 5'h00);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule